// File: doc/BRIEF.md
# CCM CBC-MAC Authentication Sequencer

This block produces the authentication tag of the CCM mode. It builds the block sequence itself: first a configuration block, then two additional-data blocks, then the message blocks. Each block goes to an external 128-bit block cipher, and each result is fed back as the chaining value for the next block. The first M bytes of the last cipher result form the tag.

A top-level controller loads the nonce, the additional data, its length and the message length, then pulses `start`. From then on a local block counter selects a 5-bit control word for every step:

| Bit | Meaning |
|-----|---------|
| 0 | latch the chaining value |
| 1 | cipher start |
| 2 | bypass the XOR |
| 4:3 | block type |

Message blocks are read from outside storage through a block index. The `mode` input chooses the source: the plaintext port for authenticate-and-encrypt, or the decrypted-stream port for verification.

Parameters: `L` is the length-field size in bytes (default 2), `M` is the tag size in bytes (default 8), and `MAX_MSG_BLKS` is the largest message in 16-byte blocks (default 64, which is 1024 bytes).

All data inputs and `mode` are held stable from `start` until `done`.

Top module: `ccm_mac_seq`

## Requirements
- R1: After reset, `done` is 0, `cipStart` is 0 and `tag` is all zeros.
- R2: The first cipher input after an accepted `start` is the configuration block, sent without any XOR. Its layout, most significant byte first, is:
  - a flags byte: bit 7 = 0, bit 6 = 1, bits 5:3 = (M-2)/2, bits 2:0 = L-1;
  - then the nonce, 15-L bytes;
  - then `msgLen` as L big-endian bytes.
- R3: The next two cipher inputs are the additional-data blocks, each XORed with the previous cipher result.
  - Together they form a 32-byte stream: `adLen` as two big-endian bytes, then `adData` bytes 0 to `adLen`-1.
  - Byte 0 of `adData` sits in bits 239:232.
  - Every byte at or beyond `adLen` reads as zero.
- R4: Then ceil(`msgLen`/16) message blocks follow, each XORed with the previous cipher result. A `msgLen` of 0 gives no message blocks. Message bytes at positions at or beyond `msgLen` read as zero. Byte 0 of a block sits in bits 127:120.
- R5: With `mode` = 0 the message block is taken from `ptBlk`. With `mode` = 1 it is taken from `decBlk`.
- R6: `cipStart` is a one-cycle pulse. It is raised once per block, and the next pulse comes only after `cipDone` has reported the previous block.
- R7: One cycle after the final `cipDone`, `done` pulses for one cycle. At that point `tag` equals bits 127:128-8M of that final `cipOut`. `tag` then holds its value.
- R8: A `start` pulse while a sequence is in progress is ignored. The block sequence and the tag are unchanged.
- R9: While a message block is sent, `msgIdx` gives its zero-based block number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a tag computation (accepted when idle) |
| mode | input | 1 | 0 = plaintext source, 1 = decrypted source |
| nonce | input | 8*(15-L) | Nonce, first byte in the top bits |
| adLen | input | 5 | Additional-data length in bytes (1 to 30) |
| adData | input | 240 | Additional-data bytes, byte 0 in the top bits |
| msgLen | input | 8*L | Message length in bytes |
| ptBlk | input | 128 | Plaintext block at `msgIdx` |
| decBlk | input | 128 | Decrypted block at `msgIdx` |
| msgIdx | output | 6 | Message block index |
| cipStart | output | 1 | Cipher start pulse |
| cipIn | output | 128 | Cipher input block |
| cipDone | input | 1 | Cipher result valid pulse |
| cipOut | input | 128 | Cipher result |
| tag | output | 8*M | Authentication tag |
| done | output | 1 | Tag valid pulse |

## Verification
A wrong block counter or control word shows up at the next `cipStart`. The bench sees a cipher input with the wrong layout, a missing XOR, a misplaced zero pad or the wrong message source, one block after the fault at the latest. Because every cipher input depends on all the earlier ones, a single bad chaining value corrupts every later `cipIn` and the tag. A wrong count of message blocks shows as an early or late `done` and as an extra or missing `cipStart`.

// File: rtl/ccm_mac_pkg.sv
package ccm_mac_pkg;
  typedef enum logic [1:0] {
    BLK_CFG = 2'b00,
    BLK_AD  = 2'b01,
    BLK_MSG = 2'b10
  } blkType_t;

  // 5-bit control word: bit0 latch, bit1 start, bit2 bypass, bits4:3 type
  typedef struct packed {
    blkType_t blkType;
    logic     bypass;
    logic     start;
    logic     latch;
  } ctlWord_t;
endpackage

// File: rtl/ccm_mac_ctrl.sv
module ccm_mac_ctrl
  import ccm_mac_pkg::*;
#(
  parameter int L = 2,
  parameter int MAX_MSG_BLKS = 64,
  localparam int LEN_W = 8 * L,
  localparam int CNT_W = $clog2(MAX_MSG_BLKS + 3),
  localparam int IDX_W = $clog2(MAX_MSG_BLKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] msgLen,
  input  logic             cipDone,
  output ctlWord_t         ctl,
  output logic             adSecond,
  output logic [IDX_W-1:0] msgIdx,
  output logic             done
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [LEN_W:0]   lenPlus;
  logic [LEN_W:0]   lastWide;
  logic [LEN_W:0]   cntWide;
  logic [CNT_W-1:0] idxFull;
  logic             isLast;

  assign lenPlus  = {1'b0, msgLen} + (LEN_W+1)'(15);
  assign lastWide = (lenPlus >> 4) + (LEN_W+1)'(2);
  assign cntWide  = (LEN_W+1)'(cnt);
  assign isLast   = (cntWide == lastWide);
  assign idxFull  = cnt - CNT_W'(3);
  assign msgIdx   = idxFull[IDX_W-1:0];
  assign adSecond = (cnt == CNT_W'(2));

  always_comb begin
    ctl = '0;
    if (cnt == '0)
      ctl.blkType = BLK_CFG;
    else if (cnt < CNT_W'(3))
      ctl.blkType = BLK_AD;
    else
      ctl.blkType = BLK_MSG;
    ctl.bypass = (cnt == '0);
    ctl.start  = (state == S_ISSUE);
    ctl.latch  = (state == S_WAIT) && cipDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          cnt   <= '0;
          state <= S_ISSUE;
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (cipDone) begin
          if (isLast) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            cnt   <= cnt + CNT_W'(1);
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_start_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.start |=> !ctl.start);
  assert_done_after_result_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(cipDone));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.start |-> (cntWide <= lastWide));
endmodule

// File: rtl/ccm_mac_dp.sv
module ccm_mac_dp
  import ccm_mac_pkg::*;
#(
  parameter int L = 2,
  parameter int M = 8,
  parameter int MAX_MSG_BLKS = 64,
  localparam int LEN_W = 8 * L,
  localparam int NONCE_W = 8 * (15 - L),
  localparam int TAG_W = 8 * M,
  localparam int IDX_W = $clog2(MAX_MSG_BLKS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlWord_t           ctl,
  input  logic               adSecond,
  input  logic [IDX_W-1:0]   msgIdx,
  input  logic               mode,
  input  logic [NONCE_W-1:0] nonce,
  input  logic [4:0]         adLen,
  input  logic [239:0]       adData,
  input  logic [LEN_W-1:0]   msgLen,
  input  logic [127:0]       ptBlk,
  input  logic [127:0]       decBlk,
  input  logic [127:0]       cipOut,
  output logic [127:0]       cipIn,
  output logic [TAG_W-1:0]   tag
);
  localparam logic [7:0] FLAGS = {2'b01, 3'((M - 2) / 2), 3'(L - 1)};

  logic [127:0] chainX;
  logic [127:0] cfgBlk;
  logic [127:0] adBlk;
  logic [127:0] msgBlk;
  logic [127:0] srcBlk;
  logic [127:0] newBlk;

  assign cfgBlk = {FLAGS, nonce, msgLen};
  assign srcBlk = mode ? decBlk : ptBlk;

  always_comb begin
    int ai;
    logic [LEN_W:0] pos;
    adBlk  = '0;
    msgBlk = '0;
    for (int k = 0; k < 16; k++) begin
      ai = adSecond ? (14 + k) : (k - 2);
      if (!adSecond && k == 0)
        adBlk[127-8*k -: 8] = 8'h00;
      else if (!adSecond && k == 1)
        adBlk[127-8*k -: 8] = {3'b000, adLen};
      else if (ai < int'(adLen))
        adBlk[127-8*k -: 8] = adData[239-8*ai -: 8];
      pos = (LEN_W+1)'({msgIdx, 4'b0000}) + (LEN_W+1)'(k);
      if (pos < {1'b0, msgLen})
        msgBlk[127-8*k -: 8] = srcBlk[127-8*k -: 8];
    end
  end

  always_comb begin
    case (ctl.blkType)
      BLK_CFG: newBlk = cfgBlk;
      BLK_AD:  newBlk = adBlk;
      default: newBlk = msgBlk;
    endcase
    cipIn = ctl.bypass ? newBlk : (newBlk ^ chainX);
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      chainX <= '0;
    else if (ctl.latch)
      chainX <= cipOut;
  end

  assign tag = chainX[127 -: TAG_W];

  assert_msgidx_bound_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.start && ctl.blkType == BLK_MSG) |-> (32'(msgIdx) < MAX_MSG_BLKS));
  assert_tag_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latch |=> $stable(tag));
endmodule

// File: rtl/ccm_mac_seq.sv
module ccm_mac_seq
  import ccm_mac_pkg::*;
#(
  parameter int L = 2,
  parameter int M = 8,
  parameter int MAX_MSG_BLKS = 64,
  localparam int LEN_W = 8 * L,
  localparam int NONCE_W = 8 * (15 - L),
  localparam int TAG_W = 8 * M,
  localparam int IDX_W = $clog2(MAX_MSG_BLKS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               mode,
  input  logic [NONCE_W-1:0] nonce,
  input  logic [4:0]         adLen,
  input  logic [239:0]       adData,
  input  logic [LEN_W-1:0]   msgLen,
  input  logic [127:0]       ptBlk,
  input  logic [127:0]       decBlk,
  output logic [IDX_W-1:0]   msgIdx,
  output logic               cipStart,
  output logic [127:0]       cipIn,
  input  logic               cipDone,
  input  logic [127:0]       cipOut,
  output logic [TAG_W-1:0]   tag,
  output logic               done
);
  ctlWord_t ctl;
  logic     adSecond;

  ccm_mac_ctrl #(.L(L), .MAX_MSG_BLKS(MAX_MSG_BLKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .msgLen(msgLen), .cipDone(cipDone),
    .ctl(ctl), .adSecond(adSecond), .msgIdx(msgIdx), .done(done)
  );

  ccm_mac_dp #(.L(L), .M(M), .MAX_MSG_BLKS(MAX_MSG_BLKS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .adSecond(adSecond), .msgIdx(msgIdx),
    .mode(mode), .nonce(nonce), .adLen(adLen), .adData(adData), .msgLen(msgLen),
    .ptBlk(ptBlk), .decBlk(decBlk), .cipOut(cipOut), .cipIn(cipIn), .tag(tag)
  );

  assign cipStart = ctl.start;
endmodule

// File: tb/ccm_mac_seq_bench.sv
module ccm_mac_seq_bench;
  logic clk = 0, rstN = 0, start = 0, mode = 0;
  logic [103:0] nonce = '0;
  logic [4:0] adLen = 5'd1;
  logic [239:0] adData = '0;
  logic [15:0] msgLen = '0;
  logic [127:0] ptBlk, decBlk, cipIn, cipOut = '0;
  logic [5:0] msgIdx;
  logic cipStart, cipDone = 0, done;
  logic [63:0] tag;

  logic [127:0] ptMem [64];
  logic [127:0] decMem [64];
  assign ptBlk  = ptMem[msgIdx];
  assign decBlk = decMem[msgIdx];

  ccm_mac_seq u_ccm_mac_seq (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, lat = 1;
  logic [127:0] expIn [$];
  logic [63:0] expTag;
  int blkSeen = 0, doneCnt = 0;

  function automatic logic [127:0] cfun(logic [127:0] x);
    return {x[100:0], x[127:101]} ^ (x >> 3) ^ 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bench cipher model
  logic [127:0] held;
  int cd = 0;
  bit busyC = 0;
  always @(posedge clk) begin
    cipDone <= 0;
    if (busyC) begin
      if (cd <= 1) begin
        cipDone <= 1;
        cipOut <= cfun(held);
        busyC <= 0;
      end else cd <= cd - 1;
    end
    if (cipStart) begin
      held <= cipIn;
      cd <= lat;
      busyC <= 1;
    end
  end

  // monitor away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rstN && cipStart) begin
      if (blkSeen < expIn.size())
        chk(cipIn == expIn[blkSeen], "R2/R3/R4/R5 cipIn", cipIn, expIn[blkSeen]);
      else
        chk(0, "R4/R6 extra cipStart", cipIn, '0);
      blkSeen++;
    end
    if (rstN && done) begin
      chk(tag == expTag, "R7 tag at done", {64'h0, tag}, {64'h0, expTag});
      doneCnt++;
    end
  end

  task automatic buildExp();
    logic [7:0] s [32];
    logic [127:0] b, x;
    int nblk;
    expIn.delete();
    b = {8'h59, nonce, msgLen};   // flags: 0x40 | ((8-2)/2)<<3 | (2-1)
    expIn.push_back(b);
    x = cfun(b);
    s[0] = 8'h00; s[1] = {3'b0, adLen};
    for (int i = 0; i < 30; i++) s[i+2] = (i < adLen) ? adData[239-8*i -: 8] : 8'h00;
    for (int h = 0; h < 2; h++) begin
      for (int k = 0; k < 16; k++) b[127-8*k -: 8] = s[16*h+k];
      expIn.push_back(x ^ b);
      x = cfun(x ^ b);
    end
    nblk = (int'(msgLen) + 15) / 16;
    for (int j = 0; j < nblk; j++) begin
      for (int k = 0; k < 16; k++)
        b[127-8*k -: 8] = (16*j + k < int'(msgLen)) ?
          (mode ? decMem[j][127-8*k -: 8] : ptMem[j][127-8*k -: 8]) : 8'h00;
      expIn.push_back(x ^ b);
      x = cfun(x ^ b);
    end
    expTag = x[127:64];
  endtask

  task automatic runSeq(input int len, input int al, input bit md, input int lt, input bit poke);
    int d0;
    msgLen = 16'(len); adLen = 5'(al); mode = md; lat = lt;
    nonce = {13{8'(len + al + 3)}} ^ 104'h1234567890abcdef0011223344;
    for (int i = 0; i < 30; i++) adData[239-8*i -: 8] = 8'(i * 17 + al);
    buildExp();
    blkSeen = 0; d0 = doneCnt;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1;                       // R8: ignored while busy
      @(negedge clk) start = 0;
    end
    while (doneCnt == d0 && cyc < 150000) @(negedge clk);
    if (cyc >= 150000) chk(0, "watchdog", '0, '0);
    repeat (lt + 6) @(negedge clk);
    chk(tag == expTag, "R7 tag held", {64'h0, tag}, {64'h0, expTag});
    chk(blkSeen == expIn.size(), "R4/R6/R8 block count", 128'(blkSeen), 128'(expIn.size()));
    chk(doneCnt == d0 + 1, "R7/R8 single done", 128'(doneCnt - d0), 128'd1);
  endtask

  initial begin
    for (int j = 0; j < 64; j++) begin
      ptMem[j]  = {4{32'(j * 7919 + 1)}} ^ 128'h5555aaaa;
      decMem[j] = {4{32'(j * 104729 + 9)}} ^ 128'hc3c3c3c3_00000000;
    end
    repeat (3) @(negedge clk);
    chk(done == 0 && cipStart == 0 && tag == '0, "R1 reset state", {64'h0, tag}, '0);
    rstN = 1;
    @(negedge clk);
    runSeq(0, 5, 0, 1, 0);     // no message blocks
    runSeq(1024, 30, 0, 3, 0); // maximum length, full ad region; R9 index range
    runSeq(37, 14, 1, 2, 0);   // R5 decrypted source, short last block
    runSeq(37, 14, 0, 2, 0);   // R5 plaintext source, same lengths
    runSeq(16, 16, 1, 5, 1);   // exact block, start during busy (R8)
    runSeq(1, 1, 0, 1, 0);     // one-byte message, one-byte ad
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule